// File: doc/BRIEF.md
# Four-Leg Triangular-Carrier PWM Modulator

This block drives the high and low gates of up to four half-bridge legs, grouped as two legs on side A (A1, A2) and two on side B (B1, B2). A single triangular carrier is shared by all legs. Each leg shifts that carrier by its own phase offset and compares the shifted value against its own reference. The upper switch of a leg is on while the reference is at or above the carrier. The lower switch is the complement. A dead-time interlock keeps the two switches of a leg from conducting together.

The carrier sweeps between two configured integer bounds. Its step rate comes from a clock divider. The divider is either a build-time constant or a run-time input, and a new run-time value is picked up only when the carrier returns to its minimum. New reference values pass through per-leg shadow registers. These load at the carrier minimum, at the carrier maximum, or at both, depending on a mode input. Each side has an enable input. A build option makes side B passive, and another removes leg A2 for single-leg A-side bridges.

Top module: `pwm4_mod`

## Requirements
- R1: With its side enabled and once dead time is met, a leg's `gate_hi` is 1 exactly when its loaded reference is greater than or equal to its carrier value, and `gate_lo` is 1 exactly when it is smaller. Both gates are registered, so they change one clock after the compare changes.
- R2: The carrier phase counts 0 to 2·H−1 and then wraps, where H = CAR_MAX−CAR_MIN. It advances one step every D clocks, where D is the active divider. The carrier value is CAR_MIN+p for p ≤ H and CAR_MIN+2H−p above that, so it reaches the minimum at p=0 and the maximum at p=H.
- R3: Leg i uses the phase (p + off_in[i]) mod 2H, so its carrier always lies within [CAR_MIN, CAR_MAX]. Offsets must be below 2H. Leg order is 0=A1, 1=A2, 2=B1, 3=B2.
- R4: `load_sel` = 0 loads all shadow references on the step into p=0, 1 loads on the step into p=H, and 2 or 3 loads on both. The new value is used from the cycle in which the carrier reaches that extreme. Reset clears every shadow to 0.
- R5: A gate rises no earlier than DEAD+1 clocks after the complementary gate of the same leg fell. Turn-off is never delayed.
- R6: `gate_hi` and `gate_lo` of one leg are never 1 together, and both are 0 during and right after reset.
- R7: Clearing a side's enable drives both gates of each of that side's legs to 0 on the next clock, with no dead-time wait. The shadow references of that side keep loading at the selected events.
- R8: With VAR_FREQ=1, `freq_in` is sampled as the new divider only on the step that wraps the phase to 0, and a value of 0 counts as 1. The reset divider is FIX_DIV.
- R9: With VAR_FREQ=0, the divider is always FIX_DIV and `freq_in` has no effect on any gate.
- R10: With SIDE_A_ONLY=1, both gates of B1 and B2 stay 0 at all times. With LEG_A2=0, both gates of A2 stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_a | input | 1 | Enable switching for legs A1 and A2 |
| en_b | input | 1 | Enable switching for legs B1 and B2 |
| load_sel | input | 2 | Shadow load instant: 0 minimum, 1 maximum, 2/3 both |
| freq_in | input | DIV_W | Clocks per carrier step (variable mode) |
| ref_in | input | NLEG×REF_W | Per-leg reference, leg 0 = A1 … leg 3 = B2 |
| off_in | input | NLEG×PH_W | Per-leg carrier phase offset, below 2H |
| gate_hi | output | NLEG | Upper switch gates |
| gate_lo | output | NLEG | Lower switch gates |

## Verification
On every clock, the bound checker enforces the gate interlock, the dead-time gap on every rising gate, the one-clock shut-off of a disabled side, the phase stepping, the rule that the divider changes only at a phase wrap, and the silence of a passive side B. Whether each gate follows the correct compare result can only be shown by the bench's cycle model. The same holds for the offsets placing each leg's carrier correctly, the choice of load instant, and the new divider taking effect from the next period. The bench drives several reference, offset, load-mode, enable and divider scenarios through that model. A second instance in fixed mode with a reduced leg set is run alongside and compared against the first.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
   localparam int NLEG = 4;      // 0=A1 1=A2 2=B1 3=B2
   localparam int LEG_A2_IDX = 1;

   typedef enum logic [1:0] {
      LD_AT_MIN  = 2'd0,
      LD_AT_MAX  = 2'd1,
      LD_AT_BOTH = 2'd2,
      LD_AT_ANY  = 2'd3
   } load_mode_e;

   function automatic bit leg_on_side_b(input int idx);
      return idx >= 2;
   endfunction
endpackage

// File: rtl/pwm4_carrier.sv
module pwm4_carrier #(
   parameter int PH_W     = 6,
   parameter int HALF     = 20,
   parameter int DIV_W    = 8,
   parameter int FIX_DIV  = 2,
   parameter bit VAR_FREQ = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] freq_in,
   output logic [PH_W-1:0]  phase,
   output logic [DIV_W-1:0] div_q,
   output logic             evt_min,
   output logic             evt_max
);
   localparam int PER = 2 * HALF;
   localparam logic [PH_W-1:0]  PH_LAST = PH_W'(PER - 1);
   localparam logic [PH_W-1:0]  PH_PRE_MAX = PH_W'(HALF - 1);
   localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(FIX_DIV);

   logic [DIV_W-1:0] pre_cnt;
   logic             step;

   assign step    = (pre_cnt >= (div_q - 1'b1));
   assign evt_min = step && (phase == PH_LAST);
   assign evt_max = step && (phase == PH_PRE_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_cnt <= '0;
         phase   <= '0;
      end else if (step) begin
         pre_cnt <= '0;
         phase   <= (phase == PH_LAST) ? '0 : phase + 1'b1;
      end else begin
         pre_cnt <= pre_cnt + 1'b1;
      end
   end

   generate
      if (VAR_FREQ) begin : g_var_div
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               div_q <= DIV_RST;
            else if (evt_min)
               div_q <= (freq_in == '0) ? DIV_W'(1) : freq_in;
         end
      end else begin : g_fix_div
         logic unused_freq;
         assign unused_freq = ^freq_in;
         assign div_q = DIV_RST;
      end
   endgenerate
endmodule

// File: rtl/pwm4_deadband.sv
module pwm4_deadband #(
   parameter int DEAD = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic want_hi,
   output logic hi_q,
   output logic lo_q
);
   localparam int CW = $clog2(DEAD + 2);
   localparam logic [CW-1:0] SAT = CW'(DEAD);

   logic [CW-1:0] hi_off_run;
   logic [CW-1:0] lo_off_run;
   logic          hi_ok;
   logic          lo_ok;

   assign hi_ok = en && want_hi  && !lo_q && (lo_off_run >= SAT);
   assign lo_ok = en && !want_hi && !hi_q && (hi_off_run >= SAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q       <= 1'b0;
         lo_q       <= 1'b0;
         hi_off_run <= '0;
         lo_off_run <= '0;
      end else begin
         hi_q       <= hi_ok;
         lo_q       <= lo_ok;
         hi_off_run <= hi_q ? '0 : ((hi_off_run >= SAT) ? SAT : hi_off_run + 1'b1);
         lo_off_run <= lo_q ? '0 : ((lo_off_run >= SAT) ? SAT : lo_off_run + 1'b1);
      end
   end
endmodule

// File: rtl/pwm4_leg.sv
module pwm4_leg #(
   parameter int REF_W   = 8,
   parameter int PH_W    = 6,
   parameter int CAR_MIN = 10,
   parameter int HALF    = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [REF_W-1:0] ref_in,
   input  logic [PH_W-1:0]  phase,
   input  logic [PH_W-1:0]  offset,
   output logic             want_hi
);
   localparam int PER = 2 * HALF;

   logic [REF_W-1:0] ref_act;
   logic [REF_W-1:0] car;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ref_act <= '0;
      else if (load)
         ref_act <= ref_in;
   end

   always_comb begin
      int q;
      q = int'(phase) + int'(offset);
      if (q >= PER)
         q = q - PER;
      if (q <= HALF)
         car = REF_W'(CAR_MIN + q);
      else
         car = REF_W'(CAR_MIN + PER - q);
   end

   assign want_hi = (ref_act >= car);
endmodule

// File: rtl/pwm4_mod.sv
module pwm4_mod
   import pwm4_pkg::*;
#(
   parameter int REF_W       = 8,
   parameter int CAR_MIN     = 10,
   parameter int CAR_MAX     = 30,
   parameter int DIV_W       = 8,
   parameter int FIX_DIV     = 2,
   parameter bit VAR_FREQ    = 1,
   parameter int DEAD        = 3,
   parameter bit SIDE_A_ONLY = 0,
   parameter bit LEG_A2      = 1,
   localparam int HALF       = CAR_MAX - CAR_MIN,
   localparam int PH_W       = $clog2(2 * HALF)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       en_a,
   input  logic                       en_b,
   input  logic [1:0]                 load_sel,
   input  logic [DIV_W-1:0]           freq_in,
   input  logic [NLEG-1:0][REF_W-1:0] ref_in,
   input  logic [NLEG-1:0][PH_W-1:0]  off_in,
   output logic [NLEG-1:0]            gate_hi,
   output logic [NLEG-1:0]            gate_lo
);
   if (CAR_MAX <= CAR_MIN) begin : g_bad_range
      $error("pwm4_mod: CAR_MAX must exceed CAR_MIN");
   end
   if (CAR_MAX >= (1 << REF_W) || CAR_MIN < 0) begin : g_bad_width
      $error("pwm4_mod: carrier bounds do not fit REF_W");
   end
   if (FIX_DIV < 1 || FIX_DIV >= (1 << DIV_W)) begin : g_bad_div
      $error("pwm4_mod: FIX_DIV out of range");
   end
   if (DEAD < 0) begin : g_bad_dead
      $error("pwm4_mod: DEAD must not be negative");
   end

   logic [PH_W-1:0]  phase;
   logic [DIV_W-1:0] div_q;
   logic             evt_min;
   logic             evt_max;
   logic             load;
   load_mode_e       mode;

   pwm4_carrier #(
      .PH_W(PH_W), .HALF(HALF), .DIV_W(DIV_W),
      .FIX_DIV(FIX_DIV), .VAR_FREQ(VAR_FREQ)
   ) u_carrier (
      .clk(clk), .rst_n(rst_n), .freq_in(freq_in),
      .phase(phase), .div_q(div_q),
      .evt_min(evt_min), .evt_max(evt_max)
   );

   assign mode = load_mode_e'(load_sel);

   always_comb begin
      unique case (mode)
         LD_AT_MIN: load = evt_min;
         LD_AT_MAX: load = evt_max;
         default:   load = evt_min || evt_max;
      endcase
   end

   for (genvar i = 0; i < NLEG; i++) begin : g_leg
      localparam bit IS_B    = leg_on_side_b(i);
      localparam bit PRESENT = IS_B ? !SIDE_A_ONLY : ((i != LEG_A2_IDX) || LEG_A2);
      logic want_hi;
      logic leg_en;

      if (PRESENT) begin : g_live
         pwm4_leg #(
            .REF_W(REF_W), .PH_W(PH_W), .CAR_MIN(CAR_MIN), .HALF(HALF)
         ) u_leg (
            .clk(clk), .rst_n(rst_n), .load(load),
            .ref_in(ref_in[i]), .phase(phase), .offset(off_in[i]),
            .want_hi(want_hi)
         );
         assign leg_en = IS_B ? en_b : en_a;
      end else begin : g_idle
         logic unused_in;
         assign unused_in = ^{ref_in[i], off_in[i]};
         assign want_hi   = 1'b0;
         assign leg_en    = 1'b0;
      end

      pwm4_deadband #(.DEAD(DEAD)) u_db (
         .clk(clk), .rst_n(rst_n), .en(leg_en), .want_hi(want_hi),
         .hi_q(gate_hi[i]), .lo_q(gate_lo[i])
      );
   end
endmodule

// File: rtl/pwm4_chk.sv
module pwm4_chk #(
   parameter int NLEG        = 4,
   parameter int PH_W        = 6,
   parameter int DIV_W       = 8,
   parameter int DEAD        = 3,
   parameter bit SIDE_A_ONLY = 0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en_a,
   input logic             en_b,
   input logic [PH_W-1:0]  phase,
   input logic [DIV_W-1:0] div_q,
   input logic [NLEG-1:0]  gate_hi,
   input logic [NLEG-1:0]  gate_lo
);
   localparam int CW = $clog2(DEAD + 3);
   localparam logic [CW-1:0] SAT = CW'(DEAD + 1);

   for (genvar i = 0; i < NLEG; i++) begin : g_leg
      logic [CW-1:0] hi_gap;
      logic [CW-1:0] lo_gap;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hi_gap <= '0;
            lo_gap <= '0;
         end else begin
            hi_gap <= gate_hi[i] ? '0 : ((hi_gap >= SAT) ? SAT : hi_gap + 1'b1);
            lo_gap <= gate_lo[i] ? '0 : ((lo_gap >= SAT) ? SAT : lo_gap + 1'b1);
         end
      end

      AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
         !(gate_hi[i] && gate_lo[i]));                                   // R6
      AST_DEAD_HI: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(gate_hi[i]) |-> (lo_gap >= SAT));                         // R5
      AST_DEAD_LO: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(gate_lo[i]) |-> (hi_gap >= SAT));                         // R5
   end

   AST_SIDE_A_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en_a |=> (gate_hi[1:0] == 2'b00 && gate_lo[1:0] == 2'b00));       // R7
   AST_SIDE_B_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en_b |=> (gate_hi[3:2] == 2'b00 && gate_lo[3:2] == 2'b00));       // R7
   AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(phase) |-> (phase == '0 || phase == $past(phase) + 1'b1)); // R2
   AST_DIV_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(div_q) |-> (phase == '0));                                // R8

   if (SIDE_A_ONLY) begin : g_passive
      AST_PASSIVE_B: assert property (@(posedge clk) disable iff (!rst_n)
         (gate_hi[3:2] == 2'b00 && gate_lo[3:2] == 2'b00));              // R10
   end
endmodule

bind pwm4_mod pwm4_chk #(
   .NLEG(pwm4_pkg::NLEG), .PH_W(PH_W), .DIV_W(DIV_W),
   .DEAD(DEAD), .SIDE_A_ONLY(SIDE_A_ONLY)
) u_chk (
   .clk(clk), .rst_n(rst_n), .en_a(en_a), .en_b(en_b),
   .phase(phase), .div_q(div_q),
   .gate_hi(gate_hi), .gate_lo(gate_lo)
);

// File: tb/pwm4_mod_bench.sv
module pwm4_mod_bench;
   localparam int CMIN = 10;
   localparam int CMAX = 30;
   localparam int H    = CMAX - CMIN;
   localparam int PER  = 2 * H;
   localparam int DT   = 3;
   localparam int FD   = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en_a = 1'b0, en_b = 1'b0;
   logic [1:0] load_sel = 2'd0;
   logic [7:0] freq_in = 8'd2;
   logic [7:0] freq2 = 8'd7;
   logic [3:0][7:0] ref_in = '0;
   logic [3:0][5:0] off_in = '0;
   logic [3:0] gate_hi, gate_lo, gate_hi2, gate_lo2;

   always #4 clk = ~clk;

   pwm4_mod #(.CAR_MIN(CMIN), .CAR_MAX(CMAX), .FIX_DIV(FD), .DEAD(DT)) u_pwm4_mod (
      .clk(clk), .rst_n(rst_n), .en_a(en_a), .en_b(en_b), .load_sel(load_sel),
      .freq_in(freq_in), .ref_in(ref_in), .off_in(off_in),
      .gate_hi(gate_hi), .gate_lo(gate_lo));

   pwm4_mod #(.CAR_MIN(CMIN), .CAR_MAX(CMAX), .FIX_DIV(FD), .DEAD(DT),
              .VAR_FREQ(1'b0), .SIDE_A_ONLY(1'b1), .LEG_A2(1'b0)) u_pwm4_mod_fix (
      .clk(clk), .rst_n(rst_n), .en_a(en_a), .en_b(en_b), .load_sel(load_sel),
      .freq_in(freq2), .ref_in(ref_in), .off_in(off_in),
      .gate_hi(gate_hi2), .gate_lo(gate_lo2));

   int errors = 0, checks = 0;
   string cur_req = "R1";
   bit cmp_fix = 1'b0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // behavioural cycle model of instance one
   int ph = 0, cnt = 0, dv = FD;
   int rm[4], hm[4], lm[4], hoff[4], loff[4];
   initial for (int i = 0; i < 4; i++) begin
      rm[i] = 0; hm[i] = 0; lm[i] = 0; hoff[i] = 0; loff[i] = 0;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         ph = 0; cnt = 0; dv = FD;
         for (int i = 0; i < 4; i++) begin
            rm[i] = 0; hm[i] = 0; lm[i] = 0; hoff[i] = 0; loff[i] = 0;
         end
      end else begin
         int nh[4], nl[4];
         bit tick, emin, emax, ld;
         tick = (cnt >= dv - 1);
         for (int i = 0; i < 4; i++) begin
            int q, car;
            bit en, want;
            q = (ph + int'(off_in[i])) % PER;
            car = (q <= H) ? CMIN + q : CMIN + PER - q;
            want = (rm[i] >= car);
            en = (i < 2) ? en_a : en_b;
            nh[i] = int'(en && want && lm[i] == 0 && loff[i] >= DT);
            nl[i] = int'(en && !want && hm[i] == 0 && hoff[i] >= DT);
         end
         for (int i = 0; i < 4; i++) begin
            hoff[i] = hm[i] ? 0 : ((hoff[i] >= DT) ? DT : hoff[i] + 1);
            loff[i] = lm[i] ? 0 : ((loff[i] >= DT) ? DT : loff[i] + 1);
            hm[i] = nh[i];
            lm[i] = nl[i];
         end
         emin = tick && ph == PER - 1;
         emax = tick && ph == H - 1;
         ld = (load_sel == 2'd0) ? emin : (load_sel == 2'd1) ? emax : (emin || emax);
         if (ld) for (int i = 0; i < 4; i++) rm[i] = int'(ref_in[i]);
         if (emin) dv = (freq_in == 0) ? 1 : int'(freq_in);
         if (tick) begin
            cnt = 0;
            ph = (ph == PER - 1) ? 0 : ph + 1;
         end else cnt++;
      end
   end

   // independent gap monitors and per-cycle comparison
   int since_lo[4], since_hi[4];
   logic [3:0] prev_hi = '0, prev_lo = '0;
   initial for (int i = 0; i < 4; i++) begin since_lo[i] = 99; since_hi[i] = 99; end

   always @(negedge clk) begin
      if (rst_n) begin
         for (int i = 0; i < 4; i++) begin
            string req;
            req = ((i < 2) ? en_a : en_b) ? cur_req : "R7";
            chk(gate_hi[i] === hm[i][0], req, $sformatf("gate_hi[%0d]", i), int'(gate_hi[i]), hm[i]);
            chk(gate_lo[i] === lm[i][0], req, $sformatf("gate_lo[%0d]", i), int'(gate_lo[i]), lm[i]);
            chk(!(gate_hi[i] && gate_lo[i]), "R6", $sformatf("overlap leg %0d", i), 1, 0);
            if (gate_hi[i] && !prev_hi[i])
               chk(since_lo[i] >= DT + 1, "R5", $sformatf("hi rise gap leg %0d", i), since_lo[i], DT + 1);
            if (gate_lo[i] && !prev_lo[i])
               chk(since_hi[i] >= DT + 1, "R5", $sformatf("lo rise gap leg %0d", i), since_hi[i], DT + 1);
            since_lo[i] = gate_lo[i] ? 0 : since_lo[i] + 1;
            since_hi[i] = gate_hi[i] ? 0 : since_hi[i] + 1;
         end
         prev_hi = gate_hi;
         prev_lo = gate_lo;
         chk(gate_hi2[3:1] == 3'b000 && gate_lo2[3:1] == 3'b000, "R10", "fix inst B/A2 gates",
             int'({gate_hi2[3:1], gate_lo2[3:1]}), 0);
         if (cmp_fix)
            chk(gate_hi2[0] === gate_hi[0] && gate_lo2[0] === gate_lo[0], "R9", "fix inst A1",
                int'({gate_hi2[0], gate_lo2[0]}), int'({gate_hi[0], gate_lo[0]}));
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(200000 * 8);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      wait_cyc(3);
      chk(gate_hi == 4'b0 && gate_lo == 4'b0, "R6", "reset gates", int'({gate_hi, gate_lo}), 0);
      rst_n = 1'b1;
      cmp_fix = 1'b1;
      // R2: plain triangle, all offsets zero
      cur_req = "R2";
      en_a = 1'b1; en_b = 1'b1;
      ref_in = {8'd10, 8'd25, 8'd15, 8'd20};
      wait_cyc(200);
      // R3: distinct offsets per leg
      cur_req = "R3";
      off_in = {6'd30, 6'd20, 6'd10, 6'd0};
      wait_cyc(200);
      // R1: boundary references
      cur_req = "R1";
      ref_in = {8'd0, 8'd9, 8'd30, 8'd10};
      wait_cyc(200);
      ref_in = {8'd29, 8'd11, 8'd255, 8'd20};
      wait_cyc(170);
      // R4: load modes with mid-period reference changes
      cur_req = "R4";
      for (int m = 0; m < 3; m++) begin
         load_sel = 2'(m + 1);
         for (int k = 0; k < 6; k++) begin
            ref_in = {8'(12 + 3 * k), 8'(28 - 2 * k), 8'(15 + k), 8'(22 - k)};
            wait_cyc(23 + 7 * k);
         end
      end
      // R7: disable sides, keep references moving
      cur_req = "R7";
      @(negedge clk) en_a = 1'b0;
      @(negedge clk);
      chk(gate_hi[1:0] == 2'b0 && gate_lo[1:0] == 2'b0, "R7", "side A off next clock",
          int'({gate_hi[1:0], gate_lo[1:0]}), 0);
      ref_in = {8'd14, 8'd26, 8'd17, 8'd27};
      wait_cyc(150);
      en_a = 1'b1; en_b = 1'b0;
      @(negedge clk);
      chk(gate_hi[3:2] == 2'b0 && gate_lo[3:2] == 2'b0, "R7", "side B off next clock",
          int'({gate_hi[3:2], gate_lo[3:2]}), 0);
      wait_cyc(150);
      en_b = 1'b1;
      wait_cyc(120);
      // R8: run-time divider changes, including zero
      cmp_fix = 1'b0;
      cur_req = "R8";
      freq_in = 8'd3;
      wait_cyc(37);
      freq_in = 8'd5;
      wait_cyc(400);
      freq_in = 8'd0;
      wait_cyc(200);
      freq_in = 8'd1;
      wait_cyc(150);
      finish_run();
   end
endmodule